// File: doc/BRIEF.md
# Single-Step Capable Clock Generator

This block derives a slow, registered stepping clock from a fast free-running system clock. A mode input chooses between two behaviours. In free-running mode the output is a square wave whose high and low phases each last a parameterised number of system cycles, about 325 µs with the default settings, which gives a period near 650 µs (about 1.537 kHz). In stepping mode the output stays low and produces one full-width pulse for each debounced press of a push button. Sequential logic under test can then be advanced one rising edge at a time.

The mode switch and the push button are asynchronous to the system clock. Each passes through its own flip-flop synchroniser. The button is then debounced and turned into a single-cycle press event. The generator accepts a mode change only while its output is low, so a switch never cuts a phase short. A press that arrives while a pulse is still in progress is held as one pending request. The mode indicator output follows the mode switch directly.

Top module: `step_clock_gen`

## Requirements
- R1: While reset is asserted and after it is released, `clk_o` is low, and in stepping mode no pulse appears without a button press.
- R2: In free-running mode (`mode_i` = 1), `clk_o` alternates high and low phases of exactly HALF = SYS_HZ / (2 * OUT_HZ) system cycles each.
- R3: In stepping mode (`mode_i` = 0), each recognised press produces exactly one `clk_o` pulse whose high time is HALF system cycles.
- R4: Holding the button produces one pulse only. A further pulse requires a release and then a new press, each recognised by the debouncer.
- R5: A button level is accepted only after it differs from the accepted level for DEBOUNCE_CYC consecutive samples. A shorter glitch produces no pulse.
- R6: The active mode changes only on a cycle in which `clk_o` is low. Every high phase, in either mode and across mode changes, lasts exactly HALF cycles.
- R7: `mode_led` equals `mode_i` at all times.
- R8: In stepping mode, `clk_o` stays low for at least HALF cycles between pulses. A press recognised during a pulse or during that low time is held, and one more pulse follows when the low time has elapsed.
- R9: Presses recognised while free-running are discarded. Returning to stepping mode does not produce a pulse from them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 1 | Mode switch: 1 free-running, 0 stepping (asynchronous) |
| btn_i | input | 1 | Push button, active high (asynchronous, may bounce) |
| clk_o | output | 1 | Generated stepping clock, registered |
| mode_led | output | 1 | Mode indicator following `mode_i` |

## Verification
A wrong counter value or a wrong phase register inside the generator shows up at `clk_o` as a pulse of the wrong width or a pulse at the wrong time. The per-cycle comparison against the behavioural model catches it on the first edge that differs. A stuck pending flag or a missed edge in the debouncer causes an extra or a missing pulse. This appears within one HALF period of the press, and the pulse counts for each stimulus scenario report it as well. A mode register that is taken while the output is high truncates a phase, and the next sample of `clk_o` exposes it.

// File: rtl/step_clock_pkg.sv
package step_clock_pkg;

   typedef enum logic {
      RUN_STEP = 1'b0,
      RUN_FREE = 1'b1
   } run_mode_e;

   function automatic int unsigned half_count(input int unsigned sys_hz,
                                              input int unsigned out_hz);
      return sys_hz / (2 * out_hz);
   endfunction

   function automatic int unsigned cnt_bits(input int unsigned n);
      return (n < 2) ? 1 : $clog2(n);
   endfunction

endpackage

// File: rtl/step_sync.sv
module step_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("step_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/step_debounce.sv
module step_debounce #(
   parameter int unsigned HOLD = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic raw,
   output logic level,
   output logic press
);
   localparam int unsigned W = step_clock_pkg::cnt_bits(HOLD);

   logic level_q;
   logic level_d;

   generate
      if (HOLD <= 1) begin : g_direct
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) level_q <= 1'b0;
            else        level_q <= raw;
         end
      end else begin : g_counted
         localparam logic [W-1:0] LAST = W'(HOLD - 1);
         logic [W-1:0] run_cnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               level_q <= 1'b0;
               run_cnt <= '0;
            end else if (raw == level_q) begin
               run_cnt <= '0;
            end else if (run_cnt == LAST) begin
               level_q <= raw;
               run_cnt <= '0;
            end else begin
               run_cnt <= run_cnt + W'(1);
            end
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) level_d <= 1'b0;
      else        level_d <= level_q;
   end

   assign level = level_q;
   assign press = level_q & ~level_d;
endmodule

// File: rtl/step_clock_core.sv
module step_clock_core
   import step_clock_pkg::*;
#(
   parameter int unsigned HALF = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic mode_s,
   input  logic press,
   output logic clk_o,
   output logic run_mode
);
   localparam int unsigned W = cnt_bits(HALF);
   localparam logic [W-1:0] LAST = W'(HALF - 1);

   run_mode_e    mode_q;
   run_mode_e    mode_req;
   logic         clk_q;
   logic         pend;
   logic [W-1:0] cnt;

   assign mode_req = run_mode_e'(mode_s);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= RUN_STEP;
         clk_q  <= 1'b0;
         cnt    <= LAST;
         pend   <= 1'b0;
      end else if (!clk_q && (mode_req != mode_q)) begin
         mode_q <= mode_req;
         cnt    <= '0;
         pend   <= 1'b0;
      end else if (mode_q == RUN_FREE) begin
         pend <= 1'b0;
         if (cnt == LAST) begin
            clk_q <= ~clk_q;
            cnt   <= '0;
         end else begin
            cnt <= cnt + W'(1);
         end
      end else if (clk_q) begin
         pend <= pend | press;
         if (cnt == LAST) begin
            clk_q <= 1'b0;
            cnt   <= '0;
         end else begin
            cnt <= cnt + W'(1);
         end
      end else if (cnt != LAST) begin
         pend <= pend | press;
         cnt  <= cnt + W'(1);
      end else if (pend | press) begin
         clk_q <= 1'b1;
         cnt   <= '0;
         pend  <= 1'b0;
      end
   end

   assign clk_o    = clk_q;
   assign run_mode = (mode_q == RUN_FREE);
endmodule

// File: rtl/step_clock_gen.sv
module step_clock_gen #(
   parameter int unsigned SYS_HZ       = 50_000_000,
   parameter int unsigned OUT_HZ       = 1537,
   parameter int unsigned DEBOUNCE_CYC = 500_000,
   parameter int unsigned SYNC_STAGES  = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic mode_i,
   input  logic btn_i,
   output logic clk_o,
   output logic mode_led
);
   localparam int unsigned HALF = step_clock_pkg::half_count(SYS_HZ, OUT_HZ);

   generate
      if (OUT_HZ == 0) begin : g_bad_out
         $error("step_clock_gen: OUT_HZ must be non-zero");
      end
      if (HALF < 2) begin : g_bad_half
         $error("step_clock_gen: SYS_HZ must be at least 4 * OUT_HZ");
      end
      if (DEBOUNCE_CYC == 0) begin : g_bad_deb
         $error("step_clock_gen: DEBOUNCE_CYC must be non-zero");
      end
   endgenerate

   logic mode_s;
   logic btn_s;
   logic btn_level;
   logic press_w;
   logic run_mode_w;

   step_sync #(.STAGES(SYNC_STAGES)) u_mode_sync (
      .clk(clk), .rst_n(rst_n), .d(mode_i), .q(mode_s)
   );

   step_sync #(.STAGES(SYNC_STAGES)) u_btn_sync (
      .clk(clk), .rst_n(rst_n), .d(btn_i), .q(btn_s)
   );

   step_debounce #(.HOLD(DEBOUNCE_CYC)) u_debounce (
      .clk(clk), .rst_n(rst_n), .raw(btn_s), .level(btn_level), .press(press_w)
   );

   step_clock_core #(.HALF(HALF)) u_core (
      .clk(clk), .rst_n(rst_n), .mode_s(mode_s), .press(press_w),
      .clk_o(clk_o), .run_mode(run_mode_w)
   );

   assign mode_led = mode_i;
endmodule

// File: rtl/step_clock_chk.sv
module step_clock_chk #(
   parameter int unsigned HALF = 2
) (
   input logic clk,
   input logic rst_n,
   input logic mode_i,
   input logic mode_led,
   input logic clk_o,
   input logic press,
   input logic run_mode
);
   logic [31:0] hi_run;
   logic [31:0] lo_run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_run <= '0;
         lo_run <= HALF;
      end else if (clk_o) begin
         hi_run <= hi_run + 32'd1;
         lo_run <= '0;
      end else begin
         hi_run <= '0;
         lo_run <= (lo_run >= HALF) ? lo_run : lo_run + 32'd1;
      end
   end

   AST_HIGH_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(clk_o) |-> (hi_run == HALF)); // R3

   AST_LOW_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(clk_o) |-> (lo_run >= HALF)); // R8

   AST_MODE_WHILE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (run_mode != $past(run_mode)) |-> !$past(clk_o)); // R6

   AST_PRESS_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      press |=> !press); // R4

   AST_LED_MIRROR: assert property (@(posedge clk) disable iff (!rst_n)
      mode_led == mode_i); // R7
endmodule

bind step_clock_gen step_clock_chk #(.HALF(HALF)) u_chk (
   .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .mode_led(mode_led),
   .clk_o(clk_o), .press(press_w), .run_mode(run_mode_w)
);

// File: tb/step_clock_gen_test.sv
`timescale 1ns/1ps
module step_clock_gen_test;
   localparam int HALF = 5;
   localparam int DEB  = 4;
   localparam int STG  = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic mode_i = 1'b0;
   logic btn_i = 1'b0;
   logic clk_o;
   logic mode_led;

   int checks = 0;
   int errors = 0;

   always #2 clk = ~clk;

   step_clock_gen #(.SYS_HZ(1000), .OUT_HZ(100), .DEBOUNCE_CYC(DEB),
                    .SYNC_STAGES(STG)) uut (
      .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .btn_i(btn_i),
      .clk_o(clk_o), .mode_led(mode_led)
   );

   // behavioural reference
   int mq[$];
   int bq[$];
   int db, dbd, dcnt;
   int rfree, mclk, mcnt, mpend;

   always @(posedge clk) begin
      int ms, bs, pr;
      if (!rst_n) begin
         mq.delete(); bq.delete();
         for (int i = 0; i < STG; i++) begin mq.push_back(0); bq.push_back(0); end
         db = 0; dbd = 0; dcnt = 0;
         rfree = 0; mclk = 0; mcnt = HALF - 1; mpend = 0;
      end else begin
         ms = mq.pop_front(); mq.push_back(int'(mode_i));
         bs = bq.pop_front(); bq.push_back(int'(btn_i));
         pr = (db == 1 && dbd == 0) ? 1 : 0;
         if (mclk == 0 && ms != rfree) begin
            rfree = ms; mcnt = 0; mpend = 0;
         end else if (rfree == 1) begin
            mpend = 0;
            if (mcnt == HALF - 1) begin mclk = 1 - mclk; mcnt = 0; end
            else mcnt++;
         end else if (mclk == 1) begin
            if (pr == 1) mpend = 1;
            if (mcnt == HALF - 1) begin mclk = 0; mcnt = 0; end
            else mcnt++;
         end else if (mcnt != HALF - 1) begin
            if (pr == 1) mpend = 1;
            mcnt++;
         end else if (mpend == 1 || pr == 1) begin
            mclk = 1; mcnt = 0; mpend = 0;
         end
         dbd = db;
         if (bs == db) dcnt = 0;
         else if (dcnt == DEB - 1) begin db = bs; dcnt = 0; end
         else dcnt++;
      end
   end

   int dut_rises = 0, mod_rises = 0, hi_len = 0, last_hi = 0;
   logic prev_o = 1'b0;
   int prev_m = 0;

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      #1;
      check(mode_led == mode_i, "R7 mode_led", int'(mode_led), int'(mode_i));
      if (!rst_n) begin
         check(clk_o == 1'b0, "R1 clk_o in reset", int'(clk_o), 0);
      end else begin
         check(int'(clk_o) == mclk, rfree ? "R2 clk_o per cycle" : "R3 clk_o per cycle",
               int'(clk_o), mclk);
         if (clk_o && !prev_o) dut_rises++;
         if (mclk == 1 && prev_m == 0) mod_rises++;
         if (clk_o) hi_len++;
         else if (prev_o) begin last_hi = hi_len; hi_len = 0; end
         prev_o = clk_o;
         prev_m = mclk;
      end
   end

   task automatic cycles(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic push(input int hold, input int gap);
      @(negedge clk) btn_i = 1'b1;
      cycles(hold);
      btn_i = 1'b0;
      cycles(gap);
   endtask

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      int base, mbase;
      cycles(5);
      rst_n = 1'b1;
      // R1: no pulse without a press
      base = dut_rises; cycles(30);
      check(dut_rises == base, "R1 idle pulses", dut_rises - base, 0);
      // R3: one press, one pulse
      base = dut_rises; push(8, 30);
      check(dut_rises - base == 1, "R3 single press", dut_rises - base, 1);
      check(last_hi == HALF, "R3 pulse width", last_hi, HALF);
      // R4: long hold gives one pulse
      base = dut_rises; push(60, 30);
      check(dut_rises - base == 1, "R4 held button", dut_rises - base, 1);
      // R5: glitch shorter than the debounce window
      base = dut_rises; push(DEB - 2, 30);
      check(dut_rises == base, "R5 short glitch", dut_rises - base, 0);
      base = dut_rises; push(DEB - 1, 30);
      check(dut_rises == base, "R5 glitch DEB-1", dut_rises - base, 0);
      // R8: second press during first pulse is queued
      base = dut_rises; push(DEB, DEB); push(DEB, 40);
      check(dut_rises - base == 2, "R8 queued press", dut_rises - base, 2);
      // R2: free-running
      @(negedge clk) mode_i = 1'b1;
      cycles(15);
      base = dut_rises; mbase = mod_rises; cycles(60);
      check(dut_rises - base == mod_rises - mbase, "R2 free rises",
            dut_rises - base, mod_rises - mbase);
      check(dut_rises - base == 6, "R2 rise count", dut_rises - base, 6);
      check(last_hi == HALF, "R2 high width", last_hi, HALF);
      // R9: press while free-running is discarded
      push(8, 10);
      // R6: request step mode while output is high
      while (clk_o !== 1'b1) @(negedge clk);
      mode_i = 1'b0;
      cycles(2 * HALF + STG + 2);
      check(last_hi == HALF, "R6 no runt pulse", last_hi, HALF);
      check(clk_o == 1'b0, "R6 low after switch", int'(clk_o), 0);
      base = dut_rises; cycles(40);
      check(dut_rises == base, "R9 discarded press", dut_rises - base, 0);
      // step mode still works afterwards
      base = dut_rises; push(8, 30);
      check(dut_rises - base == 1, "R3 press after return", dut_rises - base, 1);
      // R6: quick toggle of mode during a step pulse
      @(negedge clk) btn_i = 1'b1;
      cycles(DEB + STG + 2);
      mode_i = 1'b1;
      cycles(3);
      mode_i = 1'b0; btn_i = 1'b0;
      cycles(40);
      check(last_hi == HALF, "R6 toggle width", last_hi, HALF);
      check(dut_rises == mod_rises, "R6 total rises", dut_rises, mod_rises);
      finish_run();
   end
endmodule